// File: doc/BRIEF.md
# Open Current-Transformer Detector

This block guards a line differential protection scheme against tripping on a broken secondary circuit. On every sample strobe it takes the absolute instantaneous differential current and the instantaneous restraining current, and compares each with its value exactly one power cycle earlier. An open secondary makes the differential current rise by the same amount that the restraining current falls. When such a balanced exchange appears after a quiet, balanced period, and every supervision check passes, the block raises a latched open-CT flag. Protection logic elsewhere uses this flag to block or alarm.

Full-cycle filtered magnitudes are taken as inputs. The restraining magnitude is smoothed internally by a first-order recursive averager. A pickup setting and a charging-compensation flag shape the thresholds. Enable, master-mode and external-fault inputs gate operation. A dedicated clear input drops the flag.

Top module: `octd_top`

## Requirements
- R1: After synchronous reset `rst` the flag `oct_flag` is 0, and an asserted reset also clears a flag that was set.
- R2: A declaration needs a rise in differential current over one cycle (delta_dif > 0), with |delta_dif + delta_rst| * 8 strictly less than delta_dif. Here delta is the current sample minus the sample taken SPC strobes earlier (default SPC = 16).
- R3: The differential rise must be significant: delta_dif * 10 strictly greater than the averaged restraining magnitude.
- R4: The threshold is min(pickup, PU_ONE/4), which is 256 at the default PU_ONE = 1024. A sample qualifies as quiet only when the averaged restraining magnitude is strictly above the threshold and 2 * idif_mag is strictly below it.
- R5: A declaration is allowed only after 5*SPC consecutive quiet samples (80 at default). Any non-quiet sample restarts the count from zero.
- R6: At declaration, idif_mag * 100 must strictly exceed the averaged restraining magnitude times the slope. The slope is 5 when `chg_comp` = 1 and 15 when `chg_comp` = 0.
- R7: No declaration is made, and no sample counts as quiet, unless `en` = 1, `master` = 1 and `ext_fault` = 0 on that strobe. An external fault does not clear a flag that is already set.
- R8: Once set, the flag holds until `alarm_clr` = 1, `en` = 0 or `master` = 0. Any of these clears it on the next clock edge.
- R9: The averager is seeded by the first strobe after reset and then follows avg += (x - avg) >>> 4. The value including the present sample is used in all comparisons. No declaration is made before SPC samples have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one clock per sample |
| idif_abs | input | 16 | Absolute instantaneous differential current |
| irst_inst | input | 16 | Instantaneous restraining current |
| idif_mag | input | 16 | Full-cycle filtered differential magnitude |
| irst_mag | input | 16 | Full-cycle filtered restraining magnitude |
| en | input | 1 | Detector enable |
| master | input | 1 | Master-mode indication |
| ext_fault | input | 1 | External fault detected, inhibits detection |
| chg_comp | input | 1 | Charging compensation available (selects 5 % slope) |
| pickup | input | 16 | Differential pickup setting |
| alarm_clr | input | 1 | Clears the latched flag |
| oct_flag | output | 1 | Latched open-CT indication |

## Verification
Some properties are checked on every clock. The flag must hold while nothing clears it, and it must drop after a clear, a disable or a loss of master mode. Every rising edge of the flag must have come from a gated strobe, after at least the quiet-window count of samples, and with the slope check satisfied. The exact arithmetic boundaries cannot be seen by a per-cycle property and are left to the bench's scenarios. These cover the one-eighth match limit, the tenfold significance limit, the lesser-of threshold and the averager's response to a step. The same applies to the restart of the quiet count after a single bad sample.

// File: rtl/octd_pkg.sv
package octd_pkg;

    localparam int SMP_W  = 16;
    localparam int WIDE_W = SMP_W + 8;

    typedef logic [SMP_W-1:0]        amp_t;
    typedef logic signed [SMP_W+1:0] delta_t;
    typedef logic [WIDE_W-1:0]       wide_t;

    // One stored sample: differential and restraining instantaneous values
    typedef struct packed {
        amp_t dif;
        amp_t rst;
    } pair_t;

    // Per-sample verdict of the change comparator
    typedef struct packed {
        logic rise;
        logic match;
        logic signif;
        logic slope_ok;
    } judge_t;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic wide_t widen(amp_t a);
        return {{(WIDE_W-SMP_W){1'b0}}, a};
    endfunction

    function automatic delta_t diff_of(amp_t now_v, amp_t then_v);
        return delta_t'({2'b00, now_v}) - delta_t'({2'b00, then_v});
    endfunction

    function automatic wide_t mag_of(delta_t d);
        delta_t m;
        m = (d < 0) ? -d : d;
        return {{(WIDE_W-SMP_W-2){1'b0}}, m};
    endfunction

    function automatic amp_t min_amp(amp_t a, amp_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/octd_cycle_delay.sv
module octd_cycle_delay
    import octd_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  pair_t din,
    output pair_t dout,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    pair_t         mem [DEPTH];
    logic [AW-1:0] wp;
    phase_e        phase;

    // Oldest entry sits at the write pointer: read before overwrite
    assign dout = mem[wp];
    assign full = (phase == PH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            phase <= PH_FILL;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wp] <= din;
            if (wp == LAST) begin
                wp    <= '0;
                phase <= PH_RUN;
            end else begin
                wp <= wp + 1'b1;
            end
        end
    end

endmodule

// File: rtl/octd_iir_avg.sv
module octd_iir_avg
    import octd_pkg::*;
#(
    parameter int SHIFT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  amp_t x,
    output amp_t avg_nxt
);
    localparam int EW = SMP_W + 2;

    amp_t                 avg_q;
    logic                 seeded;
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] step;
    logic signed [EW-1:0] sum;

    always_comb begin
        err  = signed'({2'b00, x}) - signed'({2'b00, avg_q});
        step = err >>> SHIFT;
        sum  = signed'({2'b00, avg_q}) + step;
        avg_nxt = seeded ? sum[SMP_W-1:0] : x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_q  <= '0;
            seeded <= 1'b0;
        end else if (upd) begin
            avg_q  <= avg_nxt;
            seeded <= 1'b1;
        end
    end

endmodule

// File: rtl/octd_quiet_timer.sv
module octd_quiet_timer #(
    parameter int LIMIT = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic qualify,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            if (!qualify) begin
                cnt <= '0;
            end else if (cnt != TOP) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign ready = (cnt == TOP);

endmodule

// File: rtl/octd_judge.sv
module octd_judge
    import octd_pkg::*;
#(
    parameter int MATCH_SH = 3,
    parameter int KCT_DEN  = 10,
    parameter int LO_PCT   = 5,
    parameter int HI_PCT   = 15
) (
    input  pair_t  now_s,
    input  pair_t  old_s,
    input  amp_t   avg,
    input  amp_t   dif_mag,
    input  logic   slope_lo,
    output judge_t verdict
);
    delta_t d_dif;
    delta_t d_rst;
    delta_t d_sum;
    wide_t  lhs_slope;
    wide_t  rhs_slope;

    always_comb begin
        d_dif = diff_of(now_s.dif, old_s.dif);
        d_rst = diff_of(now_s.rst, old_s.rst);
        d_sum = d_dif + d_rst;

        lhs_slope = widen(dif_mag) * wide_t'(100);
        rhs_slope = widen(avg) * (slope_lo ? wide_t'(LO_PCT) : wide_t'(HI_PCT));

        verdict.rise     = (d_dif > 0);
        verdict.match    = verdict.rise && ((mag_of(d_sum) << MATCH_SH) < mag_of(d_dif));
        verdict.signif   = verdict.rise && ((mag_of(d_dif) * wide_t'(KCT_DEN)) > widen(avg));
        verdict.slope_ok = (lhs_slope > rhs_slope);
    end

endmodule

// File: rtl/octd_top.sv
module octd_top
    import octd_pkg::*;
#(
    parameter int SPC          = 16,
    parameter int QUIET_CYC    = 5,
    parameter int IIR_SH       = 4,
    parameter int PU_ONE       = 1024,
    parameter int SLOPE_LO_PCT = 5,
    parameter int SLOPE_HI_PCT = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] idif_abs,
    input  logic [SMP_W-1:0] irst_inst,
    input  logic [SMP_W-1:0] idif_mag,
    input  logic [SMP_W-1:0] irst_mag,
    input  logic             en,
    input  logic             master,
    input  logic             ext_fault,
    input  logic             chg_comp,
    input  logic [SMP_W-1:0] pickup,
    input  logic             alarm_clr,
    output logic             oct_flag
);
    localparam int   QUIET_LIM = QUIET_CYC * SPC;
    localparam amp_t THR_CAP   = amp_t'(PU_ONE / 4);

    pair_t  cur_s;
    pair_t  old_s;
    logic   full;
    amp_t   avg_nxt;
    amp_t   thr;
    logic   active;
    logic   qualify;
    logic   ready;
    judge_t verdict;
    logic   fire;
    logic   drop;

    assign cur_s = '{dif: idif_abs, rst: irst_inst};

    octd_cycle_delay #(.DEPTH(SPC)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .wr_en (smp_vld),
        .din   (cur_s),
        .dout  (old_s),
        .full  (full)
    );

    octd_iir_avg #(.SHIFT(IIR_SH)) u_avg (
        .clk     (clk),
        .rst     (rst),
        .upd     (smp_vld),
        .x       (irst_mag),
        .avg_nxt (avg_nxt)
    );

    always_comb begin
        thr     = min_amp(pickup, THR_CAP);
        active  = en && master && !ext_fault;
        qualify = active && (avg_nxt > thr) &&
                  ((widen(idif_mag) << 1) < widen(thr));
    end

    octd_quiet_timer #(.LIMIT(QUIET_LIM)) u_quiet (
        .clk     (clk),
        .rst     (rst),
        .step    (smp_vld),
        .qualify (qualify),
        .ready   (ready)
    );

    octd_judge #(
        .MATCH_SH (3),
        .KCT_DEN  (10),
        .LO_PCT   (SLOPE_LO_PCT),
        .HI_PCT   (SLOPE_HI_PCT)
    ) u_judge (
        .now_s    (cur_s),
        .old_s    (old_s),
        .avg      (avg_nxt),
        .dif_mag  (idif_mag),
        .slope_lo (chg_comp),
        .verdict  (verdict)
    );

    assign fire = smp_vld && active && full && ready &&
                  verdict.match && verdict.signif && verdict.slope_ok;
    assign drop = alarm_clr || !en || !master;

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            oct_flag <= 1'b0;
        end else if (fire) begin
            oct_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/octd_checker.sv
module octd_checker
    import octd_pkg::*;
#(
    parameter int LIMIT  = 80,
    parameter int LO_PCT = 5,
    parameter int HI_PCT = 15
) (
    input logic clk,
    input logic rst,
    input logic smp_vld,
    input logic en,
    input logic master,
    input logic ext_fault,
    input logic chg_comp,
    input logic alarm_clr,
    input logic oct_flag,
    input amp_t idif_mag,
    input amp_t avg_now
);
    localparam int SW = $clog2(LIMIT + 2);

    logic [SW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (smp_vld && seen != SW'(LIMIT + 1)) begin
            seen <= seen + 1'b1;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (oct_flag && !alarm_clr && en && master) |=> oct_flag); // R8

    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (alarm_clr || !en || !master) |=> !oct_flag); // R8

    AST_GATED_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(oct_flag) |-> $past(en && master && !ext_fault && smp_vld)); // R7

    AST_WARMUP: assert property (@(posedge clk) disable iff (rst)
        $rose(oct_flag) |-> (seen > SW'(LIMIT))); // R5

    AST_SLOPE_MET: assert property (@(posedge clk) disable iff (rst)
        $rose(oct_flag) |-> $past((widen(idif_mag) * wide_t'(100)) >
            (widen(avg_now) * (chg_comp ? wide_t'(LO_PCT) : wide_t'(HI_PCT))))); // R6

endmodule

bind octd_top octd_checker #(
    .LIMIT  (QUIET_CYC * SPC),
    .LO_PCT (SLOPE_LO_PCT),
    .HI_PCT (SLOPE_HI_PCT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .en        (en),
    .master    (master),
    .ext_fault (ext_fault),
    .chg_comp  (chg_comp),
    .alarm_clr (alarm_clr),
    .oct_flag  (oct_flag),
    .idif_mag  (idif_mag),
    .avg_now   (avg_nxt)
);

// File: tb/tb_octd_top.sv
`timescale 1ns/1ps
module tb_octd_top;
    import octd_pkg::*;

    typedef struct packed {
        int p;    // quiet samples before the event
        int qm;   // idif_mag during quiet
        int dif;  // event idif_abs
        int rs;   // event irst_inst
        int em;   // event idif_mag
        int rm;   // event irst_mag
        bit chg;
        int pick;
        bit mst;
        bit ext;
        bit exp;
        int req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{80,  0, 300, 700, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b1, 2}, // R2 exact match
        '{79,  0, 300, 700, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 5}, // R5 one short
        '{80,  0, 300, 900, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 2}, // R2 mismatch
        '{80,  0, 320, 720, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 2}, // R2 sum 40, limit
        '{80,  0, 320, 719, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b1, 2}, // R2 sum 39
        '{80,  0, 100, 900, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 3}, // R3 1000 not > 1000
        '{80,  0, 101, 899, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b1, 3}, // R3 1010 > 1000
        '{80,  0, 300, 700, 100, 1000, 1'b0,  200, 1'b1, 1'b0, 1'b0, 6}, // R6 15% fails
        '{80,  0, 300, 700, 160, 1000, 1'b0,  200, 1'b1, 1'b0, 1'b1, 6}, // R6 15% met
        '{80,  0, 300, 700, 100, 1000, 1'b1,  200, 1'b1, 1'b1, 1'b0, 7}, // R7 external fault
        '{80,  0, 300, 700, 100, 1000, 1'b1,  200, 1'b0, 1'b0, 1'b0, 7}, // R7 no master
        '{80,100, 300, 700, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 4}, // R4 200 not < 200
        '{80, 99, 300, 700, 100, 1000, 1'b1,  200, 1'b1, 1'b0, 1'b1, 4}, // R4 198 < 200
        '{80, 74, 300, 700, 100, 1000, 1'b1,  150, 1'b1, 1'b0, 1'b1, 4}, // R4 pickup smaller
        '{80, 75, 300, 700, 100, 1000, 1'b1,  150, 1'b1, 1'b0, 1'b0, 4}, // R4 pickup smaller
        '{80,127, 300, 700, 100, 1000, 1'b1, 2000, 1'b1, 1'b0, 1'b1, 4}, // R4 cap 256 used
        '{80,128, 300, 700, 100, 1000, 1'b1, 2000, 1'b1, 1'b0, 1'b0, 4}, // R4 cap 256 used
        '{80,  0, 106, 894, 100, 2000, 1'b1,  200, 1'b1, 1'b0, 1'b0, 9}, // R9 avg 1062
        '{80,  0, 107, 893, 100, 2000, 1'b1,  200, 1'b1, 1'b0, 1'b1, 9}  // R9 avg 1062
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic [SMP_W-1:0] idif_abs = '0, irst_inst = '0, idif_mag = '0, irst_mag = '0;
    logic en = 1'b1, master = 1'b1, ext_fault = 1'b0, chg_comp = 1'b1, alarm_clr = 1'b0;
    logic [SMP_W-1:0] pickup = 16'd200;
    logic oct_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    octd_top dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .idif_abs(idif_abs), .irst_inst(irst_inst),
        .idif_mag(idif_mag), .irst_mag(irst_mag),
        .en(en), .master(master), .ext_fault(ext_fault),
        .chg_comp(chg_comp), .pickup(pickup),
        .alarm_clr(alarm_clr), .oct_flag(oct_flag)
    );

    task automatic check(logic got, logic want, string what);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, got, want);
        end
    endtask

    task automatic put(int dif, int rs, int dm, int rm, bit x);
        @(negedge clk);
        smp_vld   = 1'b1;
        idif_abs  = amp_t'(dif);
        irst_inst = amp_t'(rs);
        idif_mag  = amp_t'(dm);
        irst_mag  = amp_t'(rm);
        ext_fault = x;
    endtask

    task automatic pause();
        @(negedge clk);
        smp_vld   = 1'b0;
        ext_fault = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(vec_t v);
        en = 1'b1;
        master = v.mst;
        chg_comp = v.chg;
        pickup = amp_t'(v.pick);
        alarm_clr = 1'b0;
        do_reset();
        repeat (v.p) put(0, 1000, v.qm, 1000, 1'b0);
        put(v.dif, v.rs, v.em, v.rm, v.ext);
        pause();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check(oct_flag, 1'b0, "R1 flag after reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
            check(oct_flag, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R2 steady balanced load never trips
        run_vec('{0, 0, 0, 0, 0, 0, 1'b1, 200, 1'b1, 1'b0, 1'b0, 2});
        repeat (100) put(0, 1000, 0, 1000, 1'b0);
        pause();
        check(oct_flag, 1'b0, "R2 steady load");

        // R8 latch holds through further samples and an external fault
        run_vec(VECS[0]);
        repeat (20) put(0, 1000, 0, 1000, 1'b0);
        pause();
        check(oct_flag, 1'b1, "R8 latch holds");
        repeat (3) put(0, 1000, 0, 1000, 1'b1);
        pause();
        check(oct_flag, 1'b1, "R7 external fault keeps flag");

        // R8 clear input
        @(negedge clk); alarm_clr = 1'b1;
        @(negedge clk); alarm_clr = 1'b0;
        check(oct_flag, 1'b0, "R8 alarm_clr clears");

        // R8 disable clears
        run_vec(VECS[0]);
        check(oct_flag, 1'b1, "R8 set before disable");
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check(oct_flag, 1'b0, "R8 en low clears");
        en = 1'b1;

        // R8 master loss clears
        run_vec(VECS[0]);
        @(negedge clk); master = 1'b0;
        @(negedge clk);
        check(oct_flag, 1'b0, "R8 master low clears");
        master = 1'b1;

        // R1 reset clears a set flag
        run_vec(VECS[0]);
        do_reset();
        check(oct_flag, 1'b0, "R1 reset clears flag");

        // R5 a single bad sample restarts the quiet count
        pickup = 16'd200; chg_comp = 1'b1;
        do_reset();
        repeat (60) put(0, 1000, 0, 1000, 1'b0);
        put(0, 1000, 150, 1000, 1'b0);
        repeat (79) put(0, 1000, 0, 1000, 1'b0);
        put(300, 700, 100, 1000, 1'b0);
        pause();
        check(oct_flag, 1'b0, "R5 restart after bad sample");

        do_reset();
        repeat (40) put(0, 1000, 0, 1000, 1'b0);
        put(0, 1000, 150, 1000, 1'b0);
        repeat (80) put(0, 1000, 0, 1000, 1'b0);
        put(300, 700, 100, 1000, 1'b0);
        pause();
        check(oct_flag, 1'b1, "R5 full window after restart");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule